// File: doc/BRIEF.md
# Ternary CAM Route Lookup Engine

This block resolves a search key to a forwarding result, in the same way that a router resolves a route lookup. It holds a small table of ternary entries. Each entry has a stored value, a per-bit care mask, a valid flag and an associated data word, such as an output port. On a search strobe, the key is compared against every entry in parallel, which gives one match line per entry. A priority encoder selects the lowest-numbered matching entry. That entry number then reads the associated-data storage.

Software loads the table through a single write port. Each write carries the entry number, the value, the care mask, the associated data and the valid flag. If entries are placed in order of decreasing prefix length, the lowest-index winner gives longest-prefix matching. The hit flag, the match index and the associated data are registered. They appear one cycle after the strobe.

Top module: `tcam_lookup`

## Requirements
- R1: After synchronous reset, all entries are invalid and `res_vld`, `res_hit`, `res_idx` and `res_data` are zero. A search issued before any write reports a miss.
- R2: A care-mask bit of 1 makes the corresponding key bit take part in the comparison. A care-mask bit of 0 is don't-care and always counts as equal.
- R3: An entry does not match if any single cared bit differs from the key.
- R4: When several valid entries match, `res_idx` is the numerically smallest matching entry number, encoded as an unsigned binary integer.
- R5: `res_hit` is 1 when at least one valid entry matches and 0 otherwise. On a miss, `res_idx` and `res_data` are both 0.
- R6: On a hit, `res_data` equals the associated data last written to the winning entry.
- R7: `res_vld` is 1 exactly in the cycle after each cycle where `srch_en` is 1. The result outputs keep their values in the cycles without a search.
- R8: A write with `wr_valid` = 0 marks the entry invalid. An invalid entry never matches, whatever its value and mask.
- R9: A write and a search in the same cycle: the search compares against the table as it was before that write. The next search sees the written entry.
- R10: With entries loaded longest prefix first, a key covered by several prefixes returns the longest one. A key covered only by a shorter prefix falls back to that shorter prefix.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one table entry |
| wr_idx | input | IDX_W | Entry number to write |
| wr_value | input | KEY_W | Stored value bits |
| wr_care | input | KEY_W | Care mask, 1 = compare, 0 = don't-care |
| wr_data | input | DATA_W | Associated data for the entry |
| wr_valid | input | 1 | Valid flag written with the entry |
| srch_en | input | 1 | Search strobe |
| srch_key | input | KEY_W | Key to look up |
| res_vld | output | 1 | Result valid, one cycle after the strobe |
| res_hit | output | 1 | At least one entry matched |
| res_idx | output | IDX_W | Lowest matching entry number |
| res_data | output | DATA_W | Associated data of the winning entry |

## Verification
The table update and the lookup can land on the same clock edge. This happens when `wr_en` and `srch_en` are both raised in one cycle. The bench provokes this by rewriting entry 0 to match every key, and by searching a key that the old table misses, in the same cycle. The scoreboard expects a miss for that search, because its prediction is taken from the table model before the write is applied. The bench then issues a follow-up search, which must hit entry 0 with the new data.

// File: rtl/tcam_pkg.sv
package tcam_pkg;

    localparam int DEF_ENTRIES = 4;
    localparam int DEF_KEY_W   = 5;
    localparam int DEF_DATA_W  = 4;

    // Width of an entry number, never below one bit
    function automatic int idx_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/tcam_store.sv
module tcam_store
    import tcam_pkg::*;
#(
    parameter int N_ENT  = DEF_ENTRIES,
    parameter int KEY_W  = DEF_KEY_W,
    parameter int DATA_W = DEF_DATA_W,
    localparam int IDX_W = idx_bits(N_ENT)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [IDX_W-1:0]            wr_idx,
    input  logic [KEY_W-1:0]            wr_value,
    input  logic [KEY_W-1:0]            wr_care,
    input  logic [DATA_W-1:0]           wr_data,
    input  logic                        wr_valid,
    input  logic [IDX_W-1:0]            rd_idx,
    output logic [N_ENT-1:0]            ent_valid,
    output logic [N_ENT-1:0][KEY_W-1:0] ent_value,
    output logic [N_ENT-1:0][KEY_W-1:0] ent_care,
    output logic [DATA_W-1:0]           rd_data
);

    typedef struct packed {
        logic              valid;
        logic [KEY_W-1:0]  value;
        logic [KEY_W-1:0]  care;
        logic [DATA_W-1:0] data;
    } slot_t;

    slot_t [N_ENT-1:0] slot_q;
    logic              wr_hit_range;

    assign wr_hit_range = (int'(wr_idx) < N_ENT);

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= '0;
        end else if (wr_en && wr_hit_range) begin
            slot_q[wr_idx] <= '{valid: wr_valid, value: wr_value,
                                care: wr_care, data: wr_data};
        end
    end

    for (genvar g = 0; g < N_ENT; g++) begin : g_unpack
        assign ent_valid[g] = slot_q[g].valid;
        assign ent_value[g] = slot_q[g].value;
        assign ent_care[g]  = slot_q[g].care;
    end

    assign rd_data = slot_q[rd_idx].data;

    // R8
    entry_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_hit_range) |=> (ent_valid[$past(wr_idx)] == $past(wr_valid)));

endmodule

// File: rtl/tcam_match.sv
module tcam_match
    import tcam_pkg::*;
#(
    parameter int N_ENT = DEF_ENTRIES,
    parameter int KEY_W = DEF_KEY_W
) (
    input  logic [KEY_W-1:0]            key,
    input  logic [N_ENT-1:0]            ent_valid,
    input  logic [N_ENT-1:0][KEY_W-1:0] ent_value,
    input  logic [N_ENT-1:0][KEY_W-1:0] ent_care,
    output logic [N_ENT-1:0]            match
);

    // One compare per entry: differing bits are masked by the care bits
    for (genvar g = 0; g < N_ENT; g++) begin : g_line
        logic [KEY_W-1:0] diff;
        assign diff     = (key ^ ent_value[g]) & ent_care[g];
        assign match[g] = ent_valid[g] && (diff == '0);
    end

endmodule

// File: rtl/tcam_prio.sv
module tcam_prio
    import tcam_pkg::*;
#(
    parameter int N_ENT  = DEF_ENTRIES,
    localparam int IDX_W = idx_bits(N_ENT)
) (
    input  logic [N_ENT-1:0] match,
    output logic             any,
    output logic [IDX_W-1:0] idx
);

    logic [N_ENT-1:0] below;

    always_comb begin
        idx = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (match[i]) idx = IDX_W'(i);
        end
    end

    assign any = |match;

    always_comb begin
        for (int i = 0; i < N_ENT; i++) below[i] = (i < int'(idx));
    end

    // R4
    always_comb begin
        lowest_win_chk: assert (!any || (match[idx] && ((match & below) == '0)));
    end

endmodule

// File: rtl/tcam_lookup.sv
module tcam_lookup
    import tcam_pkg::*;
#(
    parameter int N_ENT  = DEF_ENTRIES,
    parameter int KEY_W  = DEF_KEY_W,
    parameter int DATA_W = DEF_DATA_W,
    localparam int IDX_W = idx_bits(N_ENT)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [KEY_W-1:0]  wr_value,
    input  logic [KEY_W-1:0]  wr_care,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_valid,
    input  logic              srch_en,
    input  logic [KEY_W-1:0]  srch_key,
    output logic              res_vld,
    output logic              res_hit,
    output logic [IDX_W-1:0]  res_idx,
    output logic [DATA_W-1:0] res_data
);

    typedef struct packed {
        logic              hit;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] data;
    } result_t;

    logic [N_ENT-1:0]            ent_valid;
    logic [N_ENT-1:0][KEY_W-1:0] ent_value;
    logic [N_ENT-1:0][KEY_W-1:0] ent_care;
    logic [N_ENT-1:0]            match;
    logic                        any;
    logic [IDX_W-1:0]            win_idx;
    logic [DATA_W-1:0]           win_data;
    result_t                     nxt, res_q;
    logic                        vld_q;

    tcam_store #(.N_ENT(N_ENT), .KEY_W(KEY_W), .DATA_W(DATA_W)) u_store (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_value (wr_value),
        .wr_care  (wr_care),
        .wr_data  (wr_data),
        .wr_valid (wr_valid),
        .rd_idx   (win_idx),
        .ent_valid(ent_valid),
        .ent_value(ent_value),
        .ent_care (ent_care),
        .rd_data  (win_data)
    );

    tcam_match #(.N_ENT(N_ENT), .KEY_W(KEY_W)) u_match (
        .key      (srch_key),
        .ent_valid(ent_valid),
        .ent_value(ent_value),
        .ent_care (ent_care),
        .match    (match)
    );

    tcam_prio #(.N_ENT(N_ENT)) u_prio (
        .match(match),
        .any  (any),
        .idx  (win_idx)
    );

    always_comb begin
        nxt = '0;
        if (any) nxt = '{hit: 1'b1, idx: win_idx, data: win_data};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            res_q <= '0;
        end else begin
            vld_q <= srch_en;
            if (srch_en) res_q <= nxt;
        end
    end

    assign res_vld  = vld_q;
    assign res_hit  = res_q.hit;
    assign res_idx  = res_q.idx;
    assign res_data = res_q.data;

    // R7
    result_timing_chk: assert property (@(posedge clk) disable iff (rst)
        srch_en |=> res_vld);

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !srch_en |=> (!res_vld && $stable(res_hit) && $stable(res_idx) && $stable(res_data)));

    // R5
    miss_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (res_vld && !res_hit) |-> (res_idx == '0 && res_data == '0));

endmodule

// File: tb/tcam_lookup_tb.sv
`timescale 1ns/1ps
module tcam_lookup_tb;

    localparam int N  = 4;
    localparam int KW = 5;
    localparam int DW = 4;
    localparam int IW = 2;
    localparam int RW = 1 + IW + DW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [IW-1:0] wr_idx = '0;
    logic [KW-1:0] wr_value = '0;
    logic [KW-1:0] wr_care = '0;
    logic [DW-1:0] wr_data = '0;
    logic          wr_valid = 1'b0;
    logic          srch_en = 1'b0;
    logic [KW-1:0] srch_key = '0;
    logic          res_vld, res_hit;
    logic [IW-1:0] res_idx;
    logic [DW-1:0] res_data;

    int n_checks = 0;
    int n_fail   = 0;

    logic [KW-1:0] m_val  [N];
    logic [KW-1:0] m_care [N];
    logic [DW-1:0] m_dat  [N];
    logic          m_vld  [N];

    logic [RW-1:0] exp_q [$];
    string         tag_q [$];
    logic [RW-1:0] last_got = '0;

    always #2.5 clk = ~clk;

    tcam_lookup #(.N_ENT(N), .KEY_W(KW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_value(wr_value), .wr_care(wr_care), .wr_data(wr_data),
        .wr_valid(wr_valid), .srch_en(srch_en), .srch_key(srch_key),
        .res_vld(res_vld), .res_hit(res_hit), .res_idx(res_idx),
        .res_data(res_data)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    function automatic logic [RW-1:0] predict(input logic [KW-1:0] key);
        for (int i = 0; i < N; i++) begin
            if (m_vld[i] && (((key ^ m_val[i]) & m_care[i]) == '0))
                return {1'b1, IW'(i), m_dat[i]};
        end
        return '0;
    endfunction

    // Drivers are called right after a falling edge
    task automatic step();
        @(negedge clk);
        wr_en   = 1'b0;
        srch_en = 1'b0;
    endtask

    task automatic search(input logic [KW-1:0] key, input string req);
        srch_en  = 1'b1;
        srch_key = key;
        exp_q.push_back(predict(key));
        tag_q.push_back(req);
    endtask

    task automatic write_ent(input int idx, input logic [KW-1:0] v,
                             input logic [KW-1:0] c, input logic [DW-1:0] d,
                             input logic vld);
        wr_en    = 1'b1;
        wr_idx   = IW'(idx);
        wr_value = v;
        wr_care  = c;
        wr_data  = d;
        wr_valid = vld;
        m_val[idx]  = v;
        m_care[idx] = c;
        m_dat[idx]  = d;
        m_vld[idx]  = vld;
    endtask

    // Monitor: pops the scoreboard on every valid result
    always @(negedge clk) begin
        if (!rst && res_vld) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R7", "result without search", 32'(res_vld), 32'd0);
            end else begin
                logic [RW-1:0] e;
                string         t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                last_got = {res_hit, res_idx, res_data};
                check(last_got == e, t, "hit/idx/data", 32'(last_got), 32'(e));
            end
        end
    end

    initial begin
        repeat (4000) @(posedge clk);
        check(1'b0, "R7", "watchdog expired", 32'd0, 32'd1);
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            m_val[i] = '0; m_care[i] = '0; m_dat[i] = '0; m_vld[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        // R1 reset state
        check(res_vld == 1'b0, "R1", "res_vld in reset", 32'(res_vld), 32'd0);
        check(res_hit == 1'b0, "R1", "res_hit in reset", 32'(res_hit), 32'd0);
        check(res_idx == '0,   "R1", "res_idx in reset", 32'(res_idx), 32'd0);
        check(res_data == '0,  "R1", "res_data in reset", 32'(res_data), 32'd0);
        rst = 1'b0;
        step();

        search(5'b01101, "R1"); step();
        step();

        // Example table: 101XX, 0110X, 011XX, 10011
        write_ent(0, 5'b10100, 5'b11100, 4'hA, 1'b1); step();
        write_ent(1, 5'b01100, 5'b11110, 4'h5, 1'b1); step();
        write_ent(2, 5'b01100, 5'b11100, 4'h3, 1'b1); step();
        write_ent(3, 5'b10011, 5'b11111, 4'hC, 1'b1); step();

        search(5'b01101, "R4 R10"); step();   // entries 1 and 2 -> 1
        search(5'b10100, "R2");     step();   // don't-care tail -> 0
        search(5'b10011, "R6");     step();   // exact -> 3, data C
        search(5'b10010, "R3 R5");  step();   // one cared bit off -> miss
        search(5'b01110, "R10");    step();   // shorter prefix only -> 2
        step();
        // R7: idle cycle, outputs held
        check(res_vld == 1'b0, "R7", "res_vld idle", 32'(res_vld), 32'd0);
        check({res_hit, res_idx, res_data} == last_got, "R7", "held result",
              32'({res_hit, res_idx, res_data}), 32'(last_got));

        // R8: invalidate entry 1
        write_ent(1, 5'b01100, 5'b11110, 4'h5, 1'b0); step();
        search(5'b01101, "R8"); step();
        // R8: all don't-care but invalid entry must not match
        write_ent(1, 5'b00000, 5'b00000, 4'h9, 1'b0); step();
        search(5'b11111, "R8"); step();

        // R9: same-cycle write and search
        search(5'b11111, "R9");
        write_ent(0, 5'b00000, 5'b00000, 4'hF, 1'b1);
        step();
        search(5'b11111, "R9"); step();
        search(5'b01110, "R9 R4"); step();
        step();
        step();

        check(exp_q.size() == 0, "R7", "missing results", 32'(exp_q.size()), 32'd0);
        summary();
        $finish;
    end

endmodule